// File: doc/BRIEF.md
# Shadowed Fractional-Frequency PWM Channel

This block is one channel of a pulse-width generator driven through a single 32-bit control word. The output frequency comes from a phase accumulator: on every clock the programmed frequency step is added to an accumulator of `INC_W` bits. The output therefore repeats at `step * f_clk / 2^INC_W`. The duty is set by an 8-bit low-time divisor. A larger divisor gives a shorter high time: divisor 0 keeps the output high for the whole period, and divisor 255 keeps it low.

Software writes new step and divisor values into a staged copy of the control word. The running waveform keeps its active settings until software writes the word with the update-request bit set. The block then copies the staged settings into its active registers and clears the request bit itself, so software can poll for completion. While the channel is running, this copy happens at the accumulator wrap, which is the start of a new period. While the channel is disabled or stalled with a zero step, it happens on the next clock.

The channel is modelled as three states:
- `ST_OFF`: the enable bit is clear.
- `ST_STALL`: enabled with a zero active step.
- `ST_RUN`: enabled with a non-zero active step.

The next state is chosen on every clock from the enable bit and from the step that will be active after that clock. The transitions are:
- `OFF->RUN` and `OFF->STALL`: enable set.
- `RUN->STALL`: a committed zero step.
- `STALL->RUN`: a committed non-zero step.
- `RUN->OFF` and `STALL->OFF`: enable cleared.

Top module: `frac_pwm_channel`

## Requirements
- R1: The control word holds the enable bit at bit 31, the update request at bit 30, the frequency step in bits `[8 +: INC_W]` and the low-time divisor in bits 7:0. All other bits read as zero. On the clock after a write, every defined field reads back exactly as written.
- R2: After reset every field reads zero and `pwm_out` is low.
- R3: With the channel enabled and a step that divides `2^INC_W`, the waveform repeats every `2^INC_W / step` clocks.
- R4: While running, `pwm_out` is high exactly when the top 8 bits of the accumulator are below `255 - divisor`. The only exception is divisor 0, which holds the output high on every cycle. Divisor 255 gives an output that never goes high.
- R5: A write with the update bit at 0 changes the readback but not the running waveform.
- R6: While the channel runs, the update bit reads 1 from the write that sets it until the accumulator next wraps. At that wrap the staged step and divisor become active and the bit clears. A write in the same cycle as a wrap defers the commit to the following wrap.
- R7: While disabled or stalled, a pending update commits and clears the update bit on the first clock that has no write.
- R8: An active step of zero with enable set holds `pwm_out` steadily low.
- R9: Clearing the enable bit drives `pwm_out` low and holds the accumulator at zero. The step and divisor fields keep their values, so re-writing a saved word restores the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Writes `wr_data` into the control word this cycle |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, including the live update bit |
| pwm_out | output | 1 | PWM output |

## Verification
The duty function is tried with directed divisors 0, 255 and a mid value, plus a seeded random sweep of power-of-two steps and divisors. The number of high cycles over one computed period must match a bench function; this separates correct threshold direction, inversion and full-duty handling from off-by-one variants. Staged-but-uncommitted writes, commits while running (timed against the wrap distance), commits while disabled and a zero step are each driven on their own. These cases tell a correct shadowing scheme apart from one that commits early, late or never. A disable followed by readback checks that the fields are retained while the output stays low.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } chan_state_e;

    localparam int EN_BIT   = 31;
    localparam int UPD_BIT  = 30;
    localparam int STEP_LSB = 8;
    localparam int DIV_W    = 8;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg
    import frac_pwm_pkg::*;
#(
    parameter int INC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             commit,
    output logic             en,
    output logic             upd,
    output logic [INC_W-1:0] stg_inc,
    output logic [DIV_W-1:0] stg_div,
    output logic [31:0]      rd_data
);
    localparam int PAD_W = 32 - 2 - INC_W - DIV_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en      <= 1'b0;
            upd     <= 1'b0;
            stg_inc <= '0;
            stg_div <= '0;
        end else if (wr_en) begin
            en      <= wr_data[EN_BIT];
            upd     <= wr_data[UPD_BIT];
            stg_inc <= wr_data[STEP_LSB +: INC_W];
            stg_div <= wr_data[DIV_W-1:0];
        end else if (commit) begin
            upd <= 1'b0;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^wr_data[UPD_BIT-1:STEP_LSB+INC_W];
            assign rd_data = {en, upd, {PAD_W{1'b0}}, stg_inc, stg_div};
        end else begin : g_nopad
            assign rd_data = {en, upd, stg_inc, stg_div};
        end
    endgenerate

    // R1: fields read back as written on the clock after a write
    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (rd_data[EN_BIT] == $past(wr_data[EN_BIT])) &&
                         (rd_data[UPD_BIT] == $past(wr_data[UPD_BIT])) &&
                         (rd_data[STEP_LSB +: INC_W] == $past(wr_data[STEP_LSB +: INC_W])) &&
                         (rd_data[DIV_W-1:0] == $past(wr_data[DIV_W-1:0])));
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
    parameter int INC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_zero,
    input  logic [INC_W-1:0] step,
    output logic [INC_W-1:0] acc,
    output logic             wrap
);
    logic [INC_W:0] sum;

    assign sum  = {1'b0, acc} + {1'b0, step};
    assign wrap = sum[INC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         acc <= '0;
        else if (hold_zero) acc <= '0;
        else                acc <= sum[INC_W-1:0];
    end

    // R9: accumulator is held at zero while the channel is off
    a_r9_acc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold_zero |=> (acc == '0));
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
    import frac_pwm_pkg::*;
(
    input  logic             active,
    input  logic [7:0]       acc_top,
    input  logic [DIV_W-1:0] div,
    output logic             high
);
    logic [7:0] thr;

    assign thr  = 8'd255 - div;
    assign high = active && ((div == '0) || (acc_top < thr));
endmodule

// File: rtl/frac_pwm_channel.sv
module frac_pwm_channel
    import frac_pwm_pkg::*;
#(
    parameter int INC_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    localparam int TOP_LSB = INC_W - 8;

    chan_state_e      state, state_nx;
    logic             en, upd, wrap, commit, cmp_high;
    logic [INC_W-1:0] stg_inc, act_inc, inc_nx, acc;
    logic [DIV_W-1:0] stg_div, act_div;

    pwm_shadow_reg #(.INC_W(INC_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .commit  (commit),
        .en      (en),
        .upd     (upd),
        .stg_inc (stg_inc),
        .stg_div (stg_div),
        .rd_data (rd_data)
    );

    pwm_phase_acc #(.INC_W(INC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (state == ST_OFF),
        .step      (act_inc),
        .acc       (acc),
        .wrap      (wrap)
    );

    pwm_duty_cmp u_cmp (
        .active  (state == ST_RUN),
        .acc_top (acc[TOP_LSB +: 8]),
        .div     (act_div),
        .high    (cmp_high)
    );

    // Commit: running channels wait for the wrap; others take it at once.
    // A write in the same cycle always wins.
    always_comb begin
        commit = 1'b0;
        unique case (state)
            ST_RUN:   commit = upd && !wr_en && wrap;
            ST_OFF,
            ST_STALL: commit = upd && !wr_en;
            default:  commit = 1'b0;
        endcase
        inc_nx = commit ? stg_inc : act_inc;
        if (!en)                 state_nx = ST_OFF;
        else if (inc_nx == '0)   state_nx = ST_STALL;
        else                     state_nx = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            act_inc <= '0;
            act_div <= '0;
        end else begin
            state <= state_nx;
            if (commit) begin
                act_inc <= stg_inc;
                act_div <= stg_div;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN:  pwm_out = cmp_high;
            default: pwm_out = 1'b0;
        endcase
    end

    // R9: a disabled channel keeps its output low
    a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> !pwm_out);
    // R8: a zero active step never drives the output high
    a_r8_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
        (act_inc == '0) |-> !pwm_out);
    // R6: a running channel keeps its request pending until the wrap
    a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && upd && !wrap && !wr_en) |=> upd);
    // R7: an idle channel commits on the next write-free clock
    a_r7_idle_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && upd && !wr_en) |=> (!upd && act_inc == $past(stg_inc) && act_div == $past(stg_div)));
    // R5: active settings change only when a request clears
    a_r5_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(upd) && !upd && !$past(wr_en))) |-> ($stable(act_inc) && $stable(act_div)));
endmodule

// File: tb/frac_pwm_channel_test.sv
module frac_pwm_channel_test;
    localparam int INC_W = 10;
    localparam int FULL  = 1 << INC_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frac_pwm_channel #(.INC_W(INC_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    function automatic logic [31:0] word(bit en, bit upd, int inc, int div);
        return {en, upd, 12'd0, inc[INC_W-1:0], div[7:0]};
    endfunction

    function automatic int exp_high(int inc, int div);
        int cnt = 0;
        if (inc == 0) return 0;
        if (div == 0) return FULL / inc;
        for (int k = 0; k < FULL / inc; k++)
            if ((((k * inc) % FULL) >> (INC_W - 8)) < (255 - div)) cnt++;
        return cnt;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic write(logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_clear(output int n);
        n = 0;
        while (rd_data[30] && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_high(int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) c++;
        end
    endtask

    task automatic start(int inc, int div);
        int n;
        write(word(0, 0, 0, 0));
        repeat (2) @(negedge clk);
        write(word(1, 1, inc, div));
        wait_clear(n);
        repeat (4) @(negedge clk);
    endtask

    task automatic duty_check(string req, int inc, int div);
        int c;
        count_high(FULL / inc, c);
        check(c == exp_high(inc, div), req, c, exp_high(inc, div));
    endtask

    initial begin
        int n, c, inc, div;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check(rd_data == 32'd0, "R2", rd_data, 0);
        check(pwm_out == 1'b0, "R2", pwm_out, 0);

        // R1 readback of a disabled word
        write(word(0, 0, 10'h2a5, 8'h3c));
        check(rd_data == word(0, 0, 10'h2a5, 8'h3c), "R1", rd_data, word(0, 0, 10'h2a5, 8'h3c));

        // R7 idle commit clears quickly
        write(word(0, 1, 16, 100));
        wait_clear(n);
        check(n <= 2, "R7", n, 2);

        // R3/R4 directed duties
        start(16, 100); duty_check("R4", 16, 100);
        start(8, 0);    duty_check("R4", 8, 0);
        start(8, 255);  duty_check("R4", 8, 255);
        // R3 periodicity: two consecutive periods identical
        start(32, 60);
        count_high(FULL / 32, c);
        count_high(FULL / 32, n);
        check(c == n && c == exp_high(32, 60), "R3", n, exp_high(32, 60));

        // R5 staged write without update leaves waveform
        start(4, 100);
        write(word(1, 0, 64, 20));
        check(rd_data == word(1, 0, 64, 20), "R5", rd_data, word(1, 0, 64, 20));
        duty_check("R5", 4, 100);
        write(word(1, 1, 64, 20));
        wait_clear(n);
        repeat (4) @(negedge clk);
        duty_check("R5", 64, 20);

        // R6 commit waits for wrap (step 1: about 1000 clocks away)
        start(1, 128);
        repeat (10) @(negedge clk);
        write(word(1, 1, 2, 50));
        check(rd_data[30] == 1'b1, "R6", rd_data[30], 1);
        wait_clear(n);
        check(n >= 950 && n <= 1030, "R6", n, 1000);
        repeat (4) @(negedge clk);
        duty_check("R6", 2, 50);

        // R8 zero step holds output low
        start(0, 0);
        check(rd_data == word(1, 0, 0, 0), "R8", rd_data, word(1, 0, 0, 0));
        count_high(300, c);
        check(c == 0, "R8", c, 0);

        // R9 disable keeps fields, output low; restore works
        start(16, 30);
        write(word(0, 0, 16, 30));
        count_high(200, c);
        check(c == 0, "R9", c, 0);
        check(rd_data == word(0, 0, 16, 30), "R9", rd_data, word(0, 0, 16, 30));
        write(word(1, 1, 16, 30));
        wait_clear(n);
        repeat (4) @(negedge clk);
        duty_check("R9", 16, 30);

        // R3/R4 random sweep
        for (int i = 0; i < 14; i++) begin
            inc = 1 << ($urandom % 7);
            div = $urandom % 256;
            start(inc, div);
            check(rd_data == word(1, 0, inc, div), "R1", rd_data, word(1, 0, inc, div));
            duty_check("R4", inc, div);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule